// File: doc/BRIEF.md
# PS/2 Keyboard Scan Code Receiver

This block takes the clock and data lines of a PS/2 keyboard as plain inputs and turns each serial frame the keyboard sends into one parallel byte for the system. Both lines are first brought into the system clock domain. The keyboard clock is then debounced by a level filter. A shift register advances on each falling edge of the filtered clock and collects the data bits. When a frame is complete, the byte is placed on the scan code output and a ready flag is raised.

The consumer waits for the ready flag, takes the byte and then drives the read input high to clear the flag, so each byte is consumed once. The flag has its own small piece of logic. That logic merges the set request from the frame side with the clear request from the read side, so the two requests never compete inside the receiver state. The block never drives either keyboard line and never sends commands. With the usual power-up code set, one press and release of a common key delivers three bytes: a make code, then a two-byte break code.

Top module: `ps2_scan_rx`

## Requirements
- R1: After a synchronous reset, `ready_o` is 0 and `code_o` is 0x00.
- R2: A frame is 11 bits: a start bit 0, eight data bits least significant first, a parity bit and a stop bit 1. Each bit is taken on a falling edge of the filtered keyboard clock. After the stop-bit edge, `code_o` holds the data byte and `ready_o` is 1.
- R3: The parity bit is consumed but not checked. A frame with wrong (even) parity still delivers its byte and sets `ready_o`.
- R4: A frame whose stop bit is 0 is discarded. `ready_o` and `code_o` keep their previous values, and the receiver returns to idle so that the next valid frame is received correctly.
- R5: The filtered keyboard clock changes level only after the synchronized line has shown the new level for 8 consecutive system clock samples. A low pulse of 7 cycles or fewer is ignored.
- R6: In idle, a falling edge of the filtered clock with data 1 does not start a frame.
- R7: When `rd_i` is high and no byte completes in that cycle, `ready_o` is 0 in the next cycle. `code_o` is unchanged.
- R8: A byte that completes in the same cycle as a high `rd_i` still sets `ready_o` and loads `code_o`. A completing byte wins over a clear.
- R9: Bytes arriving back to back without a read each overwrite `code_o` and leave `ready_o` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kb_clk_i | input | 1 | Raw keyboard clock line |
| kb_data_i | input | 1 | Raw keyboard data line |
| rd_i | input | 1 | Level that clears the ready flag |
| code_o | output | 8 | Last received scan code |
| ready_o | output | 1 | A new scan code is waiting |

## Verification
The bench sends a 7-cycle low glitch while data is 0. A filter that is too short would start a false frame on this glitch, and the next real byte would then come out shifted. A falling edge with data held high in idle catches a receiver that starts on any edge. Frames with wrong parity and with a zero stop bit separate a design that checks parity, which would drop a good byte, from one that does not check framing, which would report a bad byte. Holding read high across a whole frame shows whether a clear that collides with a completion would lose the byte.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
    localparam int DATA_BITS = 8;
    localparam int FILT_LEN  = 8;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_DATA = 2'd1,
        RX_PAR  = 2'd2,
        RX_STOP = 2'd3
    } rx_state_t;

    typedef struct packed {
        logic                 done;
        logic [DATA_BITS-1:0] data;
    } rx_byte_t;

    function automatic logic is_last_bit(input logic [$clog2(DATA_BITS)-1:0] idx);
        return idx == ($clog2(DATA_BITS))'(DATA_BITS - 1);
    endfunction
endpackage

// File: rtl/kb_line_sync.sv
module kb_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '1;
                else if (s == 0) stage_q[s] <= async_i;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/kb_clk_filter.sv
module kb_clk_filter
    import ps2rx_pkg::*;
#(
    parameter int LEN = FILT_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic level_o,
    output logic fall_o
);
    localparam int CW = $clog2(LEN) + 1;

    logic [CW-1:0] run_q;
    logic          level_q;
    logic          fall_q;
    logic          flip;

    assign flip = (line_i != level_q) && (run_q == CW'(LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            level_q <= 1'b1;
            fall_q  <= 1'b0;
        end else begin
            fall_q <= flip && level_q;
            if (line_i == level_q) begin
                run_q <= '0;
            end else if (flip) begin
                run_q   <= '0;
                level_q <= line_i;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign level_o = level_q;
    assign fall_o  = fall_q;

    // R5
    filt_follows_line_chk: assert property (@(posedge clk) disable iff (rst)
        (level_q != $past(level_q)) |-> (level_q == $past(line_i)));
    // R5
    fall_only_on_drop_chk: assert property (@(posedge clk) disable iff (rst)
        fall_q |-> !level_q);
endmodule

// File: rtl/kb_frame_shifter.sv
module kb_frame_shifter
    import ps2rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fall_i,
    input  logic     data_i,
    output rx_byte_t rx_o
);
    localparam int IW = $clog2(DATA_BITS);

    rx_state_t            state_q;
    logic [IW-1:0]        idx_q;
    logic [DATA_BITS-1:0] shreg_q;
    rx_byte_t             out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            idx_q   <= '0;
            shreg_q <= '0;
            out_q   <= '0;
        end else begin
            out_q.done <= 1'b0;
            if (fall_i) begin
                unique case (state_q)
                    RX_IDLE: begin
                        idx_q <= '0;
                        if (!data_i) state_q <= RX_DATA;
                    end
                    RX_DATA: begin
                        shreg_q <= {data_i, shreg_q[DATA_BITS-1:1]};
                        if (is_last_bit(idx_q)) state_q <= RX_PAR;
                        else idx_q <= idx_q + 1'b1;
                    end
                    RX_PAR: state_q <= RX_STOP;
                    RX_STOP: begin
                        state_q <= RX_IDLE;
                        if (data_i) begin
                            out_q.done <= 1'b1;
                            out_q.data <= shreg_q;
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    assign rx_o = out_q;

    // R2
    done_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        out_q.done |-> ($past(state_q) == RX_STOP && $past(fall_i)));
    // R4
    bad_stop_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_STOP && fall_i && !data_i) |=> !out_q.done);
    // R6
    no_false_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_IDLE && fall_i && data_i) |=> state_q == RX_IDLE);
endmodule

// File: rtl/kb_ready_flag.sv
module kb_ready_flag
    import ps2rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  rx_byte_t             rx_i,
    input  logic                 rd_i,
    output logic [DATA_BITS-1:0] code_o,
    output logic                 ready_o
);
    logic [DATA_BITS-1:0] code_q;
    logic                 ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= '0;
            ready_q <= 1'b0;
        end else if (rx_i.done) begin
            code_q  <= rx_i.data;
            ready_q <= 1'b1;
        end else if (rd_i) begin
            ready_q <= 1'b0;
        end
    end

    assign code_o  = code_q;
    assign ready_o = ready_q;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        rx_i.done |=> (ready_q && code_q == $past(rx_i.data)));
    // R7
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !rx_i.done) |=> (!ready_q && $stable(code_q)));
    // R9
    rise_needs_byte_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_q) |-> $past(rx_i.done));
endmodule

// File: rtl/ps2_scan_rx.sv
module ps2_scan_rx
    import ps2rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       kb_clk_i,
    input  logic       kb_data_i,
    input  logic       rd_i,
    output logic [7:0] code_o,
    output logic       ready_o
);
    logic [1:0] synced;
    logic       filt_level;
    logic       filt_fall;
    rx_byte_t   rx_byte;

    kb_line_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({kb_data_i, kb_clk_i}),
        .sync_o  (synced)
    );

    kb_clk_filter #(.LEN(FILT_LEN)) u_filt (
        .clk     (clk),
        .rst     (rst),
        .line_i  (synced[0]),
        .level_o (filt_level),
        .fall_o  (filt_fall)
    );

    kb_frame_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .fall_i (filt_fall),
        .data_i (synced[1]),
        .rx_o   (rx_byte)
    );

    kb_ready_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .rx_i    (rx_byte),
        .rd_i    (rd_i),
        .code_o  (code_o),
        .ready_o (ready_o)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!ready_o && code_o == 8'h00));
    // R5
    filt_idle_high_chk: assert property (@(posedge clk)
        $past(rst) |-> filt_level);
endmodule

// File: tb/ps2_scan_rx_bench.sv
module ps2_scan_rx_bench;
    localparam int HALF = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       kb_clk = 1'b1;
    logic       kb_data = 1'b1;
    logic       rd = 1'b0;
    logic [7:0] code;
    logic       ready;
    logic       seen_clr = 1'b0;
    logic       seen_ready;
    int         n_chk = 0;
    int         n_fail = 0;

    always #10 clk = ~clk;

    ps2_scan_rx u_ps2_scan_rx (
        .clk       (clk),
        .rst       (rst),
        .kb_clk_i  (kb_clk),
        .kb_data_i (kb_data),
        .rd_i      (rd),
        .code_o    (code),
        .ready_o   (ready)
    );

    always @(posedge clk) begin
        if (seen_clr) seen_ready <= 1'b0;
        else if (ready) seen_ready <= 1'b1;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        kb_data = b;
        wait_cyc(HALF);
        kb_clk = 1'b0;
        wait_cyc(HALF);
        kb_clk = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic good_par, input logic stop);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        send_bit(good_par ? ~^b : ^b);
        send_bit(stop);
        kb_data = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic do_read();
        rd = 1'b1;
        wait_cyc(1);
        rd = 1'b0;
        wait_cyc(1);
    endtask

    task automatic t_reset();
        check("R1 ready", {7'd0, ready}, 8'h00);
        check("R1 code", code, 8'h00);
    endtask

    task automatic t_basic();
        send_frame(8'h1C, 1'b1, 1'b1);
        check("R2 ready", {7'd0, ready}, 8'h01);
        check("R2 code", code, 8'h1C);
        send_frame(8'hE7, 1'b1, 1'b1);
        check("R2 code lsb-first", code, 8'hE7);
    endtask

    task automatic t_read();
        do_read();
        check("R7 ready cleared", {7'd0, ready}, 8'h00);
        check("R7 code kept", code, 8'hE7);
    endtask

    task automatic t_parity();
        send_frame(8'hA5, 1'b0, 1'b1);
        check("R3 ready", {7'd0, ready}, 8'h01);
        check("R3 code", code, 8'hA5);
        do_read();
    endtask

    task automatic t_bad_stop();
        send_frame(8'h3C, 1'b1, 1'b0);
        check("R4 ready", {7'd0, ready}, 8'h00);
        check("R4 code kept", code, 8'hA5);
        send_frame(8'h5A, 1'b1, 1'b1);
        check("R4 recovery", code, 8'h5A);
        do_read();
    endtask

    task automatic t_glitch();
        kb_data = 1'b0;
        wait_cyc(HALF);
        kb_clk = 1'b0;
        wait_cyc(7);
        kb_clk = 1'b1;
        wait_cyc(HALF);
        kb_data = 1'b1;
        wait_cyc(HALF);
        send_frame(8'h81, 1'b1, 1'b1);
        check("R5 glitch ignored", code, 8'h81);
        check("R5 ready", {7'd0, ready}, 8'h01);
        do_read();
    endtask

    task automatic t_no_start();
        send_bit(1'b1);
        wait_cyc(HALF);
        check("R6 no frame", {7'd0, ready}, 8'h00);
        send_frame(8'h42, 1'b1, 1'b1);
        check("R6 next frame", code, 8'h42);
        do_read();
    endtask

    task automatic t_sequence();
        logic [7:0] seq [3] = '{8'h1C, 8'hF0, 8'h1C};
        for (int i = 0; i < 3; i++) begin
            send_frame(seq[i], 1'b1, 1'b1);
            check("R9 ready", {7'd0, ready}, 8'h01);
            check("R9 code", code, seq[i]);
        end
    endtask

    task automatic t_collide();
        rd = 1'b1;
        seen_clr = 1'b1;
        wait_cyc(2);
        seen_clr = 1'b0;
        send_frame(8'h33, 1'b1, 1'b1);
        check("R8 ready seen", {7'd0, seen_ready}, 8'h01);
        check("R8 code", code, 8'h33);
        rd = 1'b0;
    endtask

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);
        t_reset();
        t_basic();
        t_read();
        t_parity();
        t_bad_stop();
        t_glitch();
        t_no_start();
        t_sequence();
        t_collide();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule